// File: doc/BRIEF.md
# Indirect Register Pointer Bus Interface

This block is the processor-facing front end of a two-channel serial controller. The bus has only four addresses, but it reaches sixteen control registers per channel. Address bit 0 picks the channel. Address bit 1 picks between the channel's data register and its control path.

Control registers are reached in two steps through one register pointer that both channels share. The first control write, made while the pointer is zero, loads the pointer. The next control access, read or write, goes to the selected register, and the pointer then falls back to zero. A command code in that first byte sets the pointer's top bit, so registers 8 to 15 can be reached.

Each access is decoded into register-file strobes: write, read, data-or-control, channel and register index. A small storage bank stands in for the real registers. The vector register (2) and the master interrupt register (9) are single copies that both channels share.

Requests are single-cycle strobes (`req_valid`) and are accepted on every rising edge. There is no back-pressure: the block never stalls the bus. A read answers with `rsp_valid` and `rsp_rdata` one cycle after its strobe. `rsp_valid` cannot be held off, so the requester must take the data in that cycle.

Top module: `regptr_bus_if`

## Requirements
- R1: After reset the pointer (`cur_ptr`) is 0, `rsp_valid` is 0, `rsp_rdata` is 0x00 and all stored registers are 0x00.
- R2: A request with `req_addr[1]`=1 reaches the data register of channel `req_addr[0]` (0 = first channel, 1 = second). `rf_data`=1, `rf_chan`=`req_addr[0]` and `rf_wr` or `rf_rd` follow the request in the same cycle.
- R3: Data-register reads and writes leave `cur_ptr` unchanged.
- R4: A control write (`req_addr[1]`=0) made while `cur_ptr` is 0 loads `cur_ptr[2:0]` with `req_wdata[2:0]` and writes no register.
- R5: In that pointer-loading write, if `req_wdata[5:3]` equals 3'b001, `cur_ptr[3]` is set to 1, selecting registers 8 to 15. Any other value of `req_wdata[5:3]` leaves it 0.
- R6: A control write made while `cur_ptr` is non-zero stores `req_wdata` into register `cur_ptr` of the addressed channel, with `rf_idx`=`cur_ptr`. `cur_ptr` then becomes 0.
- R7: A control read returns register `cur_ptr` of the addressed channel and then sets `cur_ptr` to 0.
- R8: Registers 2 and 9 are single copies: a write through either channel is seen by reads through both. All other registers are held separately for each channel.
- R9: The pointer is shared. A pointer loaded through one channel's address selects the register for an access through the other channel's address.
- R10: Unimplemented control registers (0 and 14 by default) read as 0x00 and ignore writes.
- R11: A read strobe gives `rsp_valid`=1 with its data in the following cycle. A write gives no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Single-cycle access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Bit 0 channel, bit 1 data (1) / control (0) |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rsp_rdata | output | 8 | Registered read data |
| rf_wr | output | 1 | Register-file write strobe |
| rf_rd | output | 1 | Register-file read strobe |
| rf_data | output | 1 | Access targets the data register |
| rf_chan | output | 1 | Channel of the access |
| rf_idx | output | 4 | Control register index (0 for data accesses) |
| cur_ptr | output | 4 | Current register pointer |

## Verification
The `rf_*` strobes are combinational and are checked shortly after the request is driven, within the same cycle. `cur_ptr` and the register storage update on the edge that samples the strobe, so they are checked at the following falling edge. Read data appears one register later, and the bench samples `rsp_valid` and `rsp_rdata` at the falling edge after the sampling edge, which is exactly one cycle after the strobe. Every check is made at a falling edge, away from the edge where the design updates.

// File: rtl/regptr_pkg.sv
package regptr_pkg;

  typedef struct packed {
    logic ctl_wr;
    logic ctl_rd;
    logic dat_wr;
    logic dat_rd;
  } acc_kind_t;

  function automatic logic is_point_high(input logic [2:0] cmd, input logic [2:0] code);
    return cmd == code;
  endfunction

endpackage

// File: rtl/regptr_decode.sv
module regptr_decode #(
  parameter int PTR_W = 4
) (
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_addr,
  input  logic [PTR_W-1:0] ptr,
  output regptr_pkg::acc_kind_t acc,
  output logic             reg_wr,
  output logic             reg_rd,
  output logic             is_data,
  output logic             chan,
  output logic [PTR_W-1:0] idx
);
  logic ptr_zero;
  assign ptr_zero = (ptr == '0);

  always_comb begin
    acc.ctl_wr = req_valid &&  req_write && !req_addr[1];
    acc.ctl_rd = req_valid && !req_write && !req_addr[1];
    acc.dat_wr = req_valid &&  req_write &&  req_addr[1];
    acc.dat_rd = req_valid && !req_write &&  req_addr[1];
  end

  // A control write at pointer zero only loads the pointer.
  assign reg_wr  = acc.dat_wr || (acc.ctl_wr && !ptr_zero);
  assign reg_rd  = acc.dat_rd || acc.ctl_rd;
  assign is_data = req_addr[1];
  assign chan    = req_addr[0];
  assign idx     = req_addr[1] ? '0 : ptr;
endmodule

// File: rtl/regptr_pointer.sv
module regptr_pointer #(
  parameter int PTR_W = 4,
  parameter logic [2:0] PH_CODE = 3'd1,
  localparam int LOW_W = PTR_W - 1,
  localparam int CMD_HI = LOW_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic [CMD_HI:0]  wfield,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q;
  logic             hi_bit;

  assign hi_bit = regptr_pkg::is_point_high(wfield[CMD_HI:LOW_W], PH_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ctl_wr && ptr_q == '0) begin
      ptr_q <= {hi_bit, wfield[LOW_W-1:0]};
    end else if (ctl_wr || ctl_rd) begin
      ptr_q <= '0;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/regptr_bank.sv
module regptr_bank #(
  parameter int DW = 8,
  parameter int PTR_W = 4,
  localparam int NREG = 1 << PTR_W,
  localparam int NCH = 2,
  parameter logic [NREG-1:0] IMPL_MASK = 16'hBFFE,
  parameter logic [NREG-1:0] SHARED_MASK = 16'h0204
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             is_data,
  input  logic             chan,
  input  logic [PTR_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata
);
  // Register 0 is the pointer/command port and never stores anything.
  localparam logic [NREG-1:0] STORE_MASK = IMPL_MASK & ~NREG'(1);

  logic [DW-1:0] loc_rd [NCH][NREG];
  logic [DW-1:0] shr_rd [NREG];
  logic [DW-1:0] dat_rd [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] dat_q;
    always_ff @(posedge clk) begin
      if (!rst_n) dat_q <= '0;
      else if (wr_en && is_data && chan == c[0]) dat_q <= wdata;
    end
    assign dat_rd[c] = dat_q;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (STORE_MASK[i] && !SHARED_MASK[i]) begin : g_own
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
          if (!rst_n) q <= '0;
          else if (wr_en && !is_data && chan == c[0] && idx == PTR_W'(i)) q <= wdata;
        end
        assign loc_rd[c][i] = q;
      end else begin : g_none
        assign loc_rd[c][i] = '0;
      end
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_shr
    if (STORE_MASK[i] && SHARED_MASK[i]) begin : g_one
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (wr_en && !is_data && idx == PTR_W'(i)) q <= wdata;
      end
      assign shr_rd[i] = q;
    end else begin : g_none
      assign shr_rd[i] = '0;
    end
  end

  logic [DW-1:0] rd_val;
  always_comb begin
    if (is_data)               rd_val = dat_rd[chan];
    else if (SHARED_MASK[idx]) rd_val = shr_rd[idx];
    else                       rd_val = loc_rd[chan][idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/regptr_bus_if.sv
module regptr_bus_if #(
  parameter int DW = 8,
  parameter int PTR_W = 4,
  parameter logic [2:0] PH_CODE = 3'd1,
  parameter logic [(1<<PTR_W)-1:0] IMPL_MASK = 16'hBFFE,
  parameter logic [(1<<PTR_W)-1:0] SHARED_MASK = 16'h0204
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rf_wr,
  output logic             rf_rd,
  output logic             rf_data,
  output logic             rf_chan,
  output logic [PTR_W-1:0] rf_idx,
  output logic [PTR_W-1:0] cur_ptr
);
  localparam int CMD_HI = PTR_W + 1;

  regptr_pkg::acc_kind_t acc;
  logic [PTR_W-1:0]      ptr;

  regptr_decode #(.PTR_W(PTR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .ptr       (ptr),
    .acc       (acc),
    .reg_wr    (rf_wr),
    .reg_rd    (rf_rd),
    .is_data   (rf_data),
    .chan      (rf_chan),
    .idx       (rf_idx)
  );

  regptr_pointer #(.PTR_W(PTR_W), .PH_CODE(PH_CODE)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_wr (acc.ctl_wr),
    .ctl_rd (acc.ctl_rd),
    .wfield (req_wdata[CMD_HI:0]),
    .ptr    (ptr)
  );

  regptr_bank #(.DW(DW), .PTR_W(PTR_W), .IMPL_MASK(IMPL_MASK),
                .SHARED_MASK(SHARED_MASK)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (rf_wr),
    .rd_en     (rf_rd),
    .is_data   (rf_data),
    .chan      (rf_chan),
    .idx       (rf_idx),
    .wdata     (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign cur_ptr = ptr;
endmodule

// File: rtl/regptr_bus_if_chk.sv
module regptr_bus_if_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_addr_hi,
  input logic [PTR_W-2:0] wlow,
  input logic             rsp_valid,
  input logic [7:0]       rsp_rdata,
  input logic             rf_wr,
  input logic             rf_rd,
  input logic [PTR_W-1:0] cur_ptr
);
  // R3
  data_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr_hi) |=> $stable(cur_ptr));

  // R4
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_addr_hi && cur_ptr == '0)
      |=> cur_ptr[PTR_W-2:0] == $past(wlow));

  // R6
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_addr_hi && cur_ptr != '0) |=> cur_ptr == '0);

  // R7
  ctl_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_addr_hi) |=> cur_ptr == '0);

  // R10
  reg0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_addr_hi && cur_ptr == '0) |=> rsp_rdata == 8'h00);

  // R11
  rsp_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R11
  no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_wr, rf_rd}));
endmodule

bind regptr_bus_if regptr_bus_if_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr_hi (req_addr[1]),
  .wlow        (req_wdata[PTR_W-2:0]),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rf_wr       (rf_wr),
  .rf_rd       (rf_rd),
  .cur_ptr     (cur_ptr)
);

// File: tb/regptr_bus_if_tb_top.sv
`timescale 1ns/100ps
module regptr_bus_if_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [1:0] req_addr = 2'd0;
  logic [7:0] req_wdata = 8'd0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       rf_wr, rf_rd, rf_data, rf_chan;
  logic [3:0] rf_idx, cur_ptr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regptr_bus_if dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rf_wr(rf_wr), .rf_rd(rf_rd), .rf_data(rf_data),
    .rf_chan(rf_chan), .rf_idx(rf_idx), .cur_ptr(cur_ptr)
  );

  localparam logic [1:0] CTL_A = 2'd0, CTL_B = 2'd1, DAT_A = 2'd2, DAT_B = 2'd3;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R11 no rsp on write", {7'd0, rsp_valid}, 8'd0);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 rsp_valid after read", {7'd0, rsp_valid}, 8'd1);
    d = rsp_rdata;
  endtask

  task automatic t_reset();
    chk("R1 ptr", {4'd0, cur_ptr}, 8'd0);
    chk("R1 rsp_valid", {7'd0, rsp_valid}, 8'd0);
    chk("R1 rdata", rsp_rdata, 8'd0);
  endtask

  task automatic t_data();
    logic [7:0] d;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = DAT_B; req_wdata = 8'hC3;
    #1;
    chk("R2 rf strobes", {4'd0, rf_wr, rf_rd, rf_data, rf_chan}, 8'b1011);
    @(negedge clk);
    req_valid = 1'b0;
    bus_wr(DAT_A, 8'h5A);
    bus_rd(DAT_A, d); chk("R2 data A", d, 8'h5A);
    bus_rd(DAT_B, d); chk("R2 data B", d, 8'hC3);
    bus_wr(CTL_A, 8'h05);
    chk("R4 ptr=5", {4'd0, cur_ptr}, 8'd5);
    bus_wr(DAT_A, 8'h21);
    bus_rd(DAT_B, d);
    chk("R3 ptr kept", {4'd0, cur_ptr}, 8'd5);
    bus_rd(CTL_A, d);
    chk("R1 reg5 reset value", d, 8'h00);
    chk("R7 ptr cleared", {4'd0, cur_ptr}, 8'd0);
  endtask

  task automatic t_ptr_low();
    logic [7:0] d;
    bus_wr(CTL_A, 8'h03);
    chk("R4 ptr=3", {4'd0, cur_ptr}, 8'd3);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = CTL_A; req_wdata = 8'h77;
    #1;
    chk("R6 rf_idx", {3'd0, rf_wr, rf_idx}, 8'h13);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 ptr back to 0", {4'd0, cur_ptr}, 8'd0);
    bus_wr(CTL_A, 8'h03);
    bus_rd(CTL_A, d);
    chk("R7 read reg3", d, 8'h77);
  endtask

  task automatic t_point_high();
    logic [7:0] d;
    bus_wr(CTL_A, 8'h0D);
    chk("R5 ptr=13", {4'd0, cur_ptr}, 8'd13);
    bus_wr(CTL_A, 8'hAB);
    bus_wr(CTL_A, 8'h0D);
    bus_rd(CTL_A, d);
    chk("R5 reg13", d, 8'hAB);
    bus_wr(CTL_A, 8'h15);
    chk("R5 other cmd no high bit", {4'd0, cur_ptr}, 8'd5);
    bus_rd(CTL_A, d);
  endtask

  task automatic t_shared();
    logic [7:0] d;
    bus_wr(CTL_B, 8'h02); bus_wr(CTL_B, 8'h99);
    bus_wr(CTL_A, 8'h02); bus_rd(CTL_A, d);
    chk("R8 reg2 shared", d, 8'h99);
    bus_wr(CTL_A, 8'h09); bus_wr(CTL_A, 8'h44);
    bus_wr(CTL_B, 8'h09); bus_rd(CTL_B, d);
    chk("R8 reg9 shared", d, 8'h44);
    bus_wr(CTL_B, 8'h03); bus_wr(CTL_B, 8'h11);
    bus_wr(CTL_A, 8'h03); bus_rd(CTL_A, d);
    chk("R8 reg3 per channel A", d, 8'h77);
    bus_wr(CTL_B, 8'h03); bus_rd(CTL_B, d);
    chk("R8 reg3 per channel B", d, 8'h11);
  endtask

  task automatic t_ptr_shared();
    logic [7:0] d;
    bus_wr(CTL_A, 8'h04);
    bus_wr(CTL_B, 8'h66);
    bus_wr(CTL_A, 8'h04); bus_rd(CTL_B, d);
    chk("R9 reg4 B via A ptr", d, 8'h66);
    bus_wr(CTL_B, 8'h04); bus_rd(CTL_A, d);
    chk("R9 reg4 A untouched", d, 8'h00);
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    bus_rd(CTL_B, d);
    chk("R10 reg0 reads 0", d, 8'h00);
    bus_wr(CTL_A, 8'h0E);
    chk("R5 ptr=14", {4'd0, cur_ptr}, 8'd14);
    bus_wr(CTL_A, 8'hFF);
    bus_wr(CTL_A, 8'h0E); bus_rd(CTL_A, d);
    chk("R10 reg14 ignores write", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data();
    t_ptr_low();
    t_point_high();
    t_shared();
    t_ptr_shared();
    t_unimpl();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule